// File: doc/BRIEF.md
# Opcode-menu SPI flash cycle engine

This block runs single SPI flash commands on one chip-select line. Software does not send raw command bytes. It first fills an eight-entry opcode menu and a matching table of 2-bit transfer types. For each command it then writes a 24-bit flash address and up to 64 bytes of data into a buffer. A control-word write that carries the go bit picks a menu entry by its 3-bit index. The engine then runs the whole frame on its own: the opcode, an optional address phase and an optional data phase. In the data phase it either sends bytes from the buffer or stores the bytes it receives into the buffer.

The register port is a plain one. There is a single-cycle write strobe with a 5-bit word address. Reads are combinational on a separate address. Status flags report whether a cycle is running, whether it has finished and whether a request was refused. A lock bit can be set once per reset. After that, the menu and the type table no longer accept writes, so software can only use commands that were approved beforehand.

Top module: `spi_menu_engine`

## Requirements
- R1: After reset the status word (offset 0) reads 0x0002. Bit 1 (bus grant) always reads 1 and every other bit reads 0. The control word (offset 1) reads 0, chip select is high and the serial clock is low.
- R2: Control word (offset 1) layout: bit 1 go, bit 2 atomic, bit 3 prefix select, bits 6:4 menu index, bits 13:8 byte count minus one, bit 14 data-present. The other fields read back as written, and go always reads 0.
- R3: An accepted go starts a frame. Chip select is low for exactly DIV system clocks per bit sent. The frame opens with the menu byte at the chosen index, MSB first. The menu is two words, offset 4 holding entries 0..3 and offset 5 holding entries 4..7, and entry n sits in bits 8n+7:8n of the 64-bit pair. The type table at offset 3 holds two bits per entry, at bits 2n+1:2n. When the type code has bit 1 set (2 = read with address, 3 = write with address), the 24-bit address from offset 2 follows, most significant byte first.
- R4: For write types (code 1 or 3) the data phase sends buffer bytes 0..count, each MSB first. Buffer word w (offset 16+w) holds byte 4w in bits 7:0 up to byte 4w+3 in bits 31:24.
- R5: For read types (code 0 or 2) MOSI stays low through the data phase. Incoming bytes are stored into the buffer starting at byte 0, using the same byte packing as R4.
- R6: With data-present clear there is no data phase, so the frame is the opcode alone or the opcode plus the address.
- R7: The SPI port works in mode 0. The serial clock is low whenever chip select is high, MISO is sampled on rising edges, and MOSI changes only while the serial clock is low.
- R8: Status bit 0 reads 1 while a frame is running. At the end of every frame, status bit 2 (done) becomes 1.
- R9: Writing 1 to status bit 2 or bit 3 clears that flag. Writing 0 leaves it unchanged.
- R10: Status bit 3 (error) is set, and no frame starts, in two cases. The first is a go while a frame is running; the running frame then finishes unchanged. The second is a go that selects a write type with data-present clear and a nonzero count.
- R11: Writing 1 to status bit 15 sets the lock, and only reset clears it. While the lock is set, writes to offsets 3, 4 and 5 are ignored and frames keep using the earlier contents.
- R12: Status bits 14:4 are plain storage and read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 5 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| spi_sclk | output | 1 | SPI serial clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The bench builds the engine with DIV = 2. Each half period of the serial clock is then a single system clock, so the rising-edge capture and the falling-edge bit advance fall on adjacent cycles, which is the tightest timing the divider allows. This short bit time also makes a full 64-byte write with an address phase take about a thousand clocks. That brings the maximum byte count, and a go issued in the middle of a long frame, within a short run.

// File: rtl/spi_menu_engine.sv
module spi_menu_engine #(
  parameter int DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [4:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);

  localparam int HALF = DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF - 1);

  localparam logic [4:0] A_STAT = 5'd0;
  localparam logic [4:0] A_CTL  = 5'd1;
  localparam logic [4:0] A_ADDR = 5'd2;
  localparam logic [4:0] A_TYPE = 5'd3;
  localparam logic [4:0] A_MLO  = 5'd4;
  localparam logic [4:0] A_MHI  = 5'd5;

  logic        busy, st_done, st_err, st_lock;
  logic [10:0] st_rsv;
  logic        ctl_atomic, ctl_pfx, ctl_dp;
  logic [2:0]  ctl_idx;
  logic [5:0]  ctl_cnt;
  logic [23:0] addr_q;
  logic [15:0] types_q;
  logic [63:0] menu_q;
  logic [7:0]  buf_q [64];

  logic [7:0]  cur_op;
  logic [1:0]  cur_type;
  logic [23:0] cur_addr;
  logic [9:0]  bitk, total_q;
  logic [5:0]  hdr_q;
  logic [CW-1:0] divc;
  logic        sclk_q;

  logic        go_wr, bad_req, start, reject, tick, cap;
  logic [1:0]  sel_type;
  logic [5:0]  hdr_n;
  logic [6:0]  nbytes;
  logic [9:0]  dbits, tot_n;
  logic [8:0]  dk;
  logic [4:0]  ak;
  logic [5:0]  byte_j;
  logic [2:0]  bsel;

  assign go_wr    = wr_en && (wr_addr == A_CTL) && wr_data[1];
  assign sel_type = types_q[{wr_data[6:4], 1'b0} +: 2];
  assign bad_req  = sel_type[0] && !wr_data[14] && (wr_data[13:8] != 6'd0);
  assign start    = go_wr && !busy && !bad_req;
  assign reject   = go_wr && (busy || bad_req);

  assign hdr_n  = sel_type[1] ? 6'd32 : 6'd8;
  assign nbytes = {1'b0, wr_data[13:8]} + 7'd1;
  assign dbits  = wr_data[14] ? {nbytes, 3'b000} : 10'd0;
  assign tot_n  = {4'b0, hdr_n} + dbits;

  assign tick   = busy && (divc == DIV_LAST);
  assign dk     = 9'(bitk - {4'b0, hdr_q});
  assign ak     = 5'(bitk - 10'd8);
  assign byte_j = dk[8:3];
  assign bsel   = 3'd7 - dk[2:0];
  assign cap    = tick && !sclk_q && !cur_type[0] && (bitk >= {4'b0, hdr_q});

  always_comb begin
    spi_mosi = 1'b0;
    if (busy) begin
      if (bitk < 10'd8)                   spi_mosi = cur_op[3'd7 - bitk[2:0]];
      else if (bitk < {4'b0, hdr_q})      spi_mosi = cur_addr[5'd23 - ak];
      else if (cur_type[0])               spi_mosi = buf_q[byte_j][bsel];
    end
  end

  assign spi_cs_n = ~busy;
  assign spi_sclk = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; st_done <= 1'b0; st_err <= 1'b0; st_lock <= 1'b0;
      st_rsv <= '0;
      ctl_atomic <= 1'b0; ctl_pfx <= 1'b0; ctl_dp <= 1'b0;
      ctl_idx <= '0; ctl_cnt <= '0;
      addr_q <= '0; types_q <= '0; menu_q <= '0;
      cur_op <= '0; cur_type <= '0; cur_addr <= '0;
      bitk <= '0; total_q <= '0; hdr_q <= '0;
      divc <= '0; sclk_q <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_STAT: begin
            if (wr_data[2])  st_done <= 1'b0;
            if (wr_data[3])  st_err  <= 1'b0;
            if (wr_data[15]) st_lock <= 1'b1;
            st_rsv <= wr_data[14:4];
          end
          A_CTL: if (!busy) begin
            ctl_atomic <= wr_data[2];
            ctl_pfx    <= wr_data[3];
            ctl_idx    <= wr_data[6:4];
            ctl_cnt    <= wr_data[13:8];
            ctl_dp     <= wr_data[14];
          end
          A_ADDR: addr_q <= wr_data[23:0];
          A_TYPE: if (!st_lock) types_q <= wr_data[15:0];
          A_MLO:  if (!st_lock) menu_q[31:0]  <= wr_data;
          A_MHI:  if (!st_lock) menu_q[63:32] <= wr_data;
          default: ;
        endcase
      end

      if (reject) st_err <= 1'b1;

      if (start) begin
        busy     <= 1'b1;
        bitk     <= '0;
        divc     <= '0;
        sclk_q   <= 1'b0;
        cur_op   <= menu_q[{wr_data[6:4], 3'b000} +: 8];
        cur_type <= sel_type;
        cur_addr <= addr_q;
        hdr_q    <= hdr_n;
        total_q  <= tot_n;
      end else if (busy) begin
        if (tick) begin
          divc   <= '0;
          sclk_q <= ~sclk_q;
          if (sclk_q) begin
            if (bitk == total_q - 10'd1) begin
              busy    <= 1'b0;
              st_done <= 1'b1;
            end else begin
              bitk <= bitk + 10'd1;
            end
          end
        end else begin
          divc <= divc + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr[4]) begin
      for (int b = 0; b < 4; b++)
        buf_q[{wr_addr[3:0], 2'(b)}] <= wr_data[8*b +: 8];
    end
    if (cap) buf_q[byte_j][bsel] <= spi_miso;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[4]) begin
      rd_data = {buf_q[{rd_addr[3:0], 2'd3}], buf_q[{rd_addr[3:0], 2'd2}],
                 buf_q[{rd_addr[3:0], 2'd1}], buf_q[{rd_addr[3:0], 2'd0}]};
    end else begin
      case (rd_addr)
        A_STAT: rd_data = {16'b0, st_lock, st_rsv, st_err, st_done, 1'b1, busy};
        A_CTL:  rd_data = {17'b0, ctl_dp, ctl_cnt, 1'b0, ctl_idx, ctl_pfx, ctl_atomic, 2'b00};
        A_ADDR: rd_data = {8'b0, addr_q};
        A_TYPE: rd_data = {16'b0, types_q};
        A_MLO:  rd_data = menu_q[31:0];
        A_MHI:  rd_data = menu_q[63:32];
        default: rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/spi_menu_engine_chk.sv
module spi_menu_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_addr,
  input logic        go_bit,
  input logic [4:0]  rd_addr,
  input logic        go_rd,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        st_lock,
  input logic        st_done,
  input logic [63:0] menu_q,
  input logic [15:0] types_q
);

  p_cs_falls_on_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> $past(wr_en && (wr_addr == 5'd1) && go_bit));

  p_sclk_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> st_done);

  p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_lock |=> st_lock);

  p_menu_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    st_lock |=> ($stable(menu_q) && $stable(types_q)));

  p_go_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 5'd1) |-> !go_rd);

endmodule

bind spi_menu_engine spi_menu_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .go_bit(wr_data[1]), .rd_addr(rd_addr), .go_rd(rd_data[1]),
  .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .st_lock(st_lock),
  .st_done(st_done), .menu_q(menu_q), .types_q(types_q)
);

// File: tb/spi_menu_engine_tb_top.sv
module spi_menu_engine_tb_top;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_menu_engine #(.DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] pat(int i);
    return 8'h5A ^ 8'(i * 37);
  endfunction

  function automatic logic resp_bit(int n);
    logic [7:0] b;
    b = pat(n / 8);
    return b[7 - (n % 8)];
  endfunction

  int rbit = 0;
  always @(negedge spi_sclk or posedge spi_cs_n)
    if (spi_cs_n) rbit = 0; else rbit = rbit + 1;
  assign spi_miso = resp_bit(rbit);

  logic got_q[$];
  always @(posedge spi_sclk) got_q.push_back(spi_mosi);

  int mosi_glitch = 0;
  always @(spi_mosi) if (spi_sclk && !spi_cs_n) mosi_glitch = mosi_glitch + 1;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Cycle model: chip select low for exactly len*DIV clocks after a go
  int req_len = 0, req_seq = 0, seen_seq = 0, left = 0;
  always @(negedge clk) begin
    if (req_seq != seen_seq) begin
      left = req_len;
      seen_seq = req_seq;
    end
    if (rst_n) begin
      checks++;
      if (spi_cs_n !== (left == 0) || (spi_cs_n && spi_sclk)) begin
        fails++;
        $display("FAIL R3/R7 per-clock cs_n=%b sclk=%b expected cs_n=%b", spi_cs_n, spi_sclk, left == 0);
      end
      if (left > 0) left = left - 1;
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] ctl(int idx, bit dp, int cnt);
    return (32'(dp) << 14) | (32'(cnt) << 8) | (32'(idx) << 4) | 32'h2;
  endfunction

  logic exp_q[$];
  int base = 0;

  task automatic push_byte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) exp_q.push_back(b[i]);
  endtask

  task automatic start_cycle(int idx, bit dp, int cnt);
    base = got_q.size();
    wr(5'd1, ctl(idx, dp, cnt));
    req_len = exp_q.size() * DIV;
    req_seq = req_seq + 1;
  endtask

  task automatic finish_cycle(string tag);
    int bad;
    @(negedge clk);
    #1 wait (left == 0);
    repeat (2) @(posedge clk);
    check({tag, " bit count"}, got_q.size() - base, exp_q.size());
    bad = 0;
    for (int i = 0; i < exp_q.size() && base + i < got_q.size(); i++)
      if (got_q[base + i] !== exp_q[i]) bad++;
    check({tag, " mosi stream mismatches"}, bad, 0);
    exp_q.delete();
  endtask

  logic [31:0] v;

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;

    rd(5'd0, v); check("R1 status after reset", v, 32'h2);
    rd(5'd1, v); check("R1 control after reset", v, 32'h0);
    check("R1 cs_n idle", 32'(spi_cs_n), 1);
    check("R1 sclk idle", 32'(spi_sclk), 0);

    wr(5'd4, 32'h0503029F);
    wr(5'd5, 32'h200BD806);
    wr(5'd3, 32'h0000ED2C);
    rd(5'd3, v); check("R3 type table readback", v, 32'hED2C);
    rd(5'd5, v); check("R3 menu high readback", v, 32'h200BD806);

    // R5: read without address, 3 bytes
    wr(5'd16, 32'h0);
    push_byte(8'h9F); for (int i = 0; i < 3; i++) push_byte(8'h00);
    start_cycle(0, 1, 2);
    finish_cycle("R3 R5 read-no-addr");
    rd(5'd16, v); check("R5 captured bytes", v, {8'h00, pat(3), pat(2), pat(1)});
    rd(5'd1, v);  check("R2 control readback go clear", v, 32'h4200);
    rd(5'd0, v);  check("R8 done after frame", v, 32'h6);
    wr(5'd0, 32'h0);
    rd(5'd0, v);  check("R9 write 0 keeps done", v, 32'h6);
    wr(5'd0, 32'h4);
    rd(5'd0, v);  check("R9 write 1 clears done", v, 32'h2);

    // R4: write with address, 4 bytes
    wr(5'd2, 32'h00123456);
    wr(5'd16, 32'hA1B2C3D4);
    push_byte(8'h02); push_byte(8'h12); push_byte(8'h34); push_byte(8'h56);
    push_byte(8'hD4); push_byte(8'hC3); push_byte(8'hB2); push_byte(8'hA1);
    start_cycle(1, 1, 3);
    repeat (4) @(posedge clk);
    rd(5'd0, v); check("R8 busy bit during frame", v & 32'h1, 32'h1);
    finish_cycle("R3 R4 write-addr");

    // R5: read with address, 5 bytes
    wr(5'd2, 32'h00ABCDEF);
    wr(5'd16, 32'h0); wr(5'd17, 32'h0);
    push_byte(8'h03); push_byte(8'hAB); push_byte(8'hCD); push_byte(8'hEF);
    for (int i = 0; i < 5; i++) push_byte(8'h00);
    start_cycle(2, 1, 4);
    finish_cycle("R3 R5 read-addr");
    rd(5'd16, v); check("R5 captured word 0", v, {pat(7), pat(6), pat(5), pat(4)});
    rd(5'd17, v); check("R5 captured word 1", v, {24'h0, pat(8)});

    // R6: no data phase
    push_byte(8'h06);
    start_cycle(4, 0, 0);
    finish_cycle("R6 opcode only");
    wr(5'd2, 32'h00010203);
    push_byte(8'hD8); push_byte(8'h01); push_byte(8'h02); push_byte(8'h03);
    start_cycle(5, 0, 0);
    finish_cycle("R6 opcode and address");
    wr(5'd0, 32'hC);

    // R10: write type with data-present clear and nonzero count
    wr(5'd1, ctl(4, 0, 5));
    repeat (4) @(posedge clk);
    rd(5'd0, v); check("R10 bad request sets error only", v, 32'hA);
    check("R10 bad request leaves cs_n high", 32'(spi_cs_n), 1);
    wr(5'd0, 32'h8);
    rd(5'd0, v); check("R9 write 1 clears error", v, 32'h2);

    // R4/R10: 64-byte write, go issued mid-frame
    wr(5'd2, 32'h00000100);
    for (int w = 0; w < 16; w++)
      wr(5'(16 + w), {8'(28*w + 22), 8'(28*w + 15), 8'(28*w + 8), 8'(28*w + 1)});
    push_byte(8'h20); push_byte(8'h00); push_byte(8'h01); push_byte(8'h00);
    for (int i = 0; i < 64; i++) push_byte(8'(7*i + 1));
    start_cycle(7, 1, 63);
    repeat (100) @(posedge clk);
    wr(5'd1, ctl(0, 1, 2));
    rd(5'd0, v); check("R10 go while busy sets error", v & 32'h9, 32'h9);
    finish_cycle("R4 R10 full buffer write");
    rd(5'd0, v); check("R8 R10 status after long frame", v, 32'hE);
    wr(5'd0, 32'hC);

    // R12
    wr(5'd0, 32'h7FF0);
    rd(5'd0, v); check("R12 reserved bits kept", v, 32'h7FF2);

    // R11
    wr(5'd0, 32'h8000);
    rd(5'd0, v); check("R11 lock set", v, 32'h8002);
    wr(5'd4, 32'hFFFFFFFF);
    wr(5'd3, 32'h0);
    rd(5'd4, v); check("R11 menu ignores write", v, 32'h0503029F);
    rd(5'd3, v); check("R11 types ignore write", v, 32'hED2C);
    wr(5'd0, 32'h0);
    rd(5'd0, v); check("R11 lock stays set", v, 32'h8002);
    push_byte(8'h06);
    start_cycle(4, 0, 0);
    finish_cycle("R11 locked menu used");

    check("R7 mosi stable while sclk high", mosi_glitch, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule